// File: doc/BRIEF.md
# SPI Sector Write-Protection Engine

This block is an SPI mode 0 slave that answers the small set of commands a serial NOR flash uses for persistent, per-sector write protection. It holds one protection byte for each 64 KiB sector of a 16 MiB address space, a single lock bit that gates changes to those bytes, and a status byte carrying a write-in-progress flag and a write-enable latch. A host enables writes, programs a sector's protection byte to the protected value, polls status until the modelled busy time has passed, and finally clears the lock bit so that no further protection changes are possible until the next reset.

The SPI pins are brought into the system clock domain by synchronizers, so the SPI clock must run several times slower than the system clock. Array reads, page program, erase, multi-lane modes and real nonvolatile storage are not part of the block; the protection array simply keeps its contents across reset.

Top module: `sect_guard`

## Requirements
- R1: After reset the status byte reads 0x00, the lock byte reads 0x01, and `spi_dout` is 0 while `spi_sel_n` is high.
- R2: Opcode 0x06 followed by a rise of `spi_sel_n` after exactly 8 bits sets the write-enable latch, so status reads 0x02.
- R3: Opcode 0x05 shifts out the status byte (bit 0 write-in-progress, bit 1 write-enable latch, other bits 0) MSB first, changing on falling `spi_clk`, and repeats it for each further byte clocked.
- R4: Opcode 0xE3 with a 32-bit address sets the addressed sector's byte to 0x00 only when `spi_sel_n` rises after exactly 40 bits; any other bit count discards it and leaves the latch set.
- R5: Opcode 0xE3 is ignored, with the latch left unchanged, when the write-enable latch is clear or the lock bit is 0.
- R6: Opcode 0xE2 with a 32-bit address shifts out the addressed sector's protection byte, 0xFF meaning unprotected and 0x00 protected.
- R7: The sector index is address bits 23:16, so 0x00FFFF and 0x010000 select different bytes; 256 bytes cover the space.
- R8: Opcode 0xA7 shifts out the lock byte, whose bit 0 is the lock bit and other bits are 0.
- R9: Opcode 0xA6 after exactly 8 bits clears the lock bit when the write-enable latch is set, and is ignored otherwise; the lock bit never returns to 1 except through reset.
- R10: An accepted program or lock clear holds write-in-progress for BUSY_CYCLES system clocks (status 0x03), after which status reads 0x00.
- R11: While write-in-progress is set only opcode 0x05 is honoured; other reads shift out 0 and other commands have no effect.
- R12: Reset returns the lock bit to 1 and clears the status bits but keeps every protection byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | SPI serial clock, mode 0 |
| spi_sel_n | input | 1 | SPI chip select, active low |
| spi_din | input | 1 | Serial data from host, sampled on rising `spi_clk` |
| spi_dout | output | 1 | Serial data to host, driven on falling `spi_clk`, 0 when idle |

## Verification
On every cycle the assertions check that write-in-progress never stands without the write-enable latch, that a protection write only reaches the array with the latch set, the lock open and no operation running, that the lock bit never reopens outside reset, that the busy timer is never restarted while running, and that the serial output stays low with chip select high. The exact-bit-count rule, the sector decoding at the 64 KiB boundary, the status value during and after the busy window, the refusals without write enable, and the survival of the array across reset can only be shown by the bench's transaction scenarios, which read the results back through the serial interface.

// File: rtl/sect_guard_pkg.sv
package sect_guard_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_PRD    = 8'hE2;
  localparam logic [7:0] OP_PPROG  = 8'hE3;
  localparam logic [7:0] OP_LRD    = 8'hA7;
  localparam logic [7:0] OP_LCLR   = 8'hA6;
  localparam int         OP_BITS   = 8;
  localparam logic [7:0] PROT_SET  = 8'h00;
  localparam logic [7:0] PROT_NONE = 8'hFF;
endpackage

// File: rtl/sect_guard_sync.sv
module sect_guard_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_clk,
  input  logic spi_sel_n,
  input  logic spi_din,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_start,
  output logic sel_stop,
  output logic din
);
  logic [STAGES:0]   sck_p;
  logic [STAGES:0]   seln_p;
  logic [STAGES-1:0] din_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      seln_p <= '1;
      din_p  <= '0;
    end else begin
      sck_p  <= {sck_p[STAGES-1:0], spi_clk};
      seln_p <= {seln_p[STAGES-1:0], spi_sel_n};
      din_p  <= {din_p[STAGES-2:0], spi_din};
    end
  end

  assign sck_rise  =  sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall  = ~sck_p[STAGES-1] &  sck_p[STAGES];
  assign sel       = ~seln_p[STAGES-1];
  assign sel_start = ~seln_p[STAGES-1] &  seln_p[STAGES];
  assign sel_stop  =  seln_p[STAGES-1] & ~seln_p[STAGES];
  assign din       =  din_p[STAGES-1];
endmodule

// File: rtl/sect_guard_ram.sv
module sect_guard_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Power-up content: every sector unprotected. Reset does not touch it.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/sect_guard_busy.sv
module sect_guard_busy #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] left;

  assign done = busy && (left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (start) begin
      busy <= 1'b1;
      left <= CW'(CYCLES);
    end else if (busy) begin
      left <= left - CW'(1);
      if (left == CW'(1)) busy <= 1'b0;
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start); // R11
endmodule

// File: rtl/sect_guard_ctrl.sv
module sect_guard_ctrl
  import sect_guard_pkg::*;
#(
  parameter int ADDR_BITS = 32,
  parameter int SECT_LSB  = 16,
  parameter int SECT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sck_rise,
  input  logic                 sck_fall,
  input  logic                 sel,
  input  logic                 sel_start,
  input  logic                 sel_stop,
  input  logic                 din,
  input  logic                 busy,
  input  logic                 done,
  input  logic [7:0]           rd_data,
  output logic                 start_busy,
  output logic                 wr_en,
  output logic [7:0]           wr_data,
  output logic [SECT_BITS-1:0] sect,
  output logic                 miso
);
  localparam int HDR_BITS = OP_BITS + ADDR_BITS;
  localparam int CW       = $clog2(HDR_BITS + 16) + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_OP  = CW'(OP_BITS);
  localparam logic [CW-1:0] CNT_HDR = CW'(HDR_BITS);

  logic [ADDR_BITS-1:0] sr, sr_next;
  logic [CW-1:0]        cnt, cnt_next;
  logic [7:0]           opc;
  logic                 wel, lock;
  logic                 ld1, ld2;
  logic [7:0]           tx;
  logic                 out_act;
  logic                 wren_ok, lclr_ok, prog_ok;

  assign sr_next  = {sr[ADDR_BITS-2:0], din};
  assign cnt_next = (cnt == CNT_MAX) ? cnt : cnt + CW'(1);

  // Decisions taken at the end of a transaction.
  assign wren_ok = (opc == OP_WREN)  && (cnt == CNT_OP)  && !busy;
  assign lclr_ok = (opc == OP_LCLR)  && (cnt == CNT_OP)  && !busy && wel;
  assign prog_ok = (opc == OP_PPROG) && (cnt == CNT_HDR) && !busy && wel && lock;

  assign start_busy = sel_stop && (lclr_ok || prog_ok);
  assign wr_en      = sel_stop && prog_ok;
  assign wr_data    = PROT_SET;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      cnt     <= '0;
      opc     <= '0;
      sect    <= '0;
      wel     <= 1'b0;
      lock    <= 1'b1;
      ld1     <= 1'b0;
      ld2     <= 1'b0;
      tx      <= '0;
      out_act <= 1'b0;
      miso    <= 1'b0;
    end else begin
      // A byte boundary past the opcode requests a new output byte; two
      // cycles of delay cover the array read.
      ld1 <= sel && sck_rise && (cnt_next[2:0] == 3'd0) && (cnt_next >= CNT_OP);
      ld2 <= ld1;

      if (sel_start) begin
        cnt     <= '0;
        opc     <= '0;
        out_act <= 1'b0;
      end else if (sel && sck_rise) begin
        sr  <= sr_next;
        cnt <= cnt_next;
        if (cnt_next == CNT_OP)  opc  <= sr_next[7:0];
        if (cnt_next == CNT_HDR) sect <= sr_next[SECT_LSB +: SECT_BITS];
      end

      if (ld2) begin
        if (opc == OP_STATUS) begin
          tx      <= {6'b0, wel, busy};
          out_act <= 1'b1;
        end else if (!busy && opc == OP_LRD) begin
          tx      <= {7'b0, lock};
          out_act <= 1'b1;
        end else if (!busy && opc == OP_PRD && cnt >= CNT_HDR) begin
          tx      <= rd_data;
          out_act <= 1'b1;
        end
      end

      if (sel && sck_fall) begin
        if (out_act) begin
          miso <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end else begin
          miso <= 1'b0;
        end
      end
      if (!sel) miso <= 1'b0;

      if (sel_stop) begin
        out_act <= 1'b0;
        if (wren_ok) wel  <= 1'b1;
        if (lclr_ok) lock <= 1'b0;
      end
      if (done) wel <= 1'b0;
    end
  end

  AST_WIP_HAS_WEL: assert property (@(posedge clk) disable iff (rst)
    busy |-> wel); // R10
  AST_PROG_GATED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wel && lock && !busy)); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    !lock |=> !lock); // R9
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sel && !sel_start) |=> !miso); // R1
endmodule

// File: rtl/sect_guard.sv
module sect_guard #(
  parameter int BUSY_CYCLES = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 32,
  parameter int SECT_LSB    = 16,
  parameter int SECT_BITS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_clk,
  input  logic spi_sel_n,
  input  logic spi_din,
  output logic spi_dout
);
  logic                 sck_rise, sck_fall, sel, sel_start, sel_stop, din;
  logic                 busy, done, start_busy, wr_en;
  logic [7:0]           wr_data, rd_data;
  logic [SECT_BITS-1:0] sect;

  sect_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_din(spi_din), .sck_rise(sck_rise), .sck_fall(sck_fall), .sel(sel),
    .sel_start(sel_start), .sel_stop(sel_stop), .din(din)
  );

  sect_guard_ctrl #(
    .ADDR_BITS(ADDR_BITS), .SECT_LSB(SECT_LSB), .SECT_BITS(SECT_BITS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel(sel), .sel_start(sel_start), .sel_stop(sel_stop), .din(din),
    .busy(busy), .done(done), .rd_data(rd_data), .start_busy(start_busy),
    .wr_en(wr_en), .wr_data(wr_data), .sect(sect), .miso(spi_dout)
  );

  sect_guard_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(start_busy), .busy(busy), .done(done)
  );

  sect_guard_ram #(.AW(SECT_BITS), .DW(8)) u_ram (
    .clk(clk), .we(wr_en), .addr(sect), .wdata(wr_data), .rdata(rd_data)
  );
endmodule

// File: tb/sect_guard_bench.sv
module sect_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int BUSY       = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_clk = 1'b0;
  logic spi_sel_n = 1'b1;
  logic spi_din = 1'b0;
  logic spi_dout;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sect_guard #(.BUSY_CYCLES(BUSY)) u_sect_guard (
    .clk(clk), .rst(rst), .spi_clk(spi_clk), .spi_sel_n(spi_sel_n),
    .spi_din(spi_din), .spi_dout(spi_dout)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input int nb, input logic [63:0] w, output logic [63:0] r);
    r = '0;
    spi_sel_n = 1'b0;
    clks(4);
    for (int i = 0; i < nb; i++) begin
      spi_din = w[63-i];
      clks(HALF);
      r = {r[62:0], spi_dout};
      spi_clk = 1'b1;
      clks(HALF);
      spi_clk = 1'b0;
    end
    clks(HALF);
    spi_sel_n = 1'b1;
    clks(12);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [63:0] r;
    xfer(8, {op, 56'b0}, r);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [63:0] r;
    xfer(16, {8'h05, 56'b0}, r);
    s = r[7:0];
  endtask

  task automatic rd_lock(output logic [7:0] s);
    logic [63:0] r;
    xfer(16, {8'hA7, 56'b0}, r);
    s = r[7:0];
  endtask

  task automatic rd_prot(input logic [31:0] a, output logic [7:0] s);
    logic [63:0] r;
    xfer(48, {8'hE2, a, 24'b0}, r);
    s = r[7:0];
  endtask

  task automatic prog(input logic [31:0] a, input int nb);
    logic [63:0] r;
    xfer(nb, {8'hE3, a, 24'b0}, r);
  endtask

  task automatic wait_idle(output int polls);
    logic [7:0] s;
    polls = 0;
    for (int k = 0; k < 40; k++) begin
      rd_status(s);
      polls++;
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic t_reset_state();
    logic [7:0] s;
    check("R1 dout idle", {7'b0, spi_dout}, 8'h00);
    rd_status(s); check("R1 status after reset", s, 8'h00);
    rd_lock(s);   check("R1 R8 lock byte after reset", s, 8'h01);
  endtask

  task automatic t_wren();
    logic [63:0] r;
    cmd(8'h06);
    xfer(24, {8'h05, 56'b0}, r);
    check("R2 R3 status first byte", r[15:8], 8'h02);
    check("R3 status repeated byte", r[7:0], 8'h02);
  endtask

  task automatic t_bad_length();
    logic [7:0] s;
    prog(32'h0000_0000, 48);
    rd_status(s); check("R4 48-bit program discarded, latch kept", s, 8'h02);
    rd_prot(32'h0000_0000, s); check("R4 sector 0 untouched", s, 8'hFF);
    prog(32'h0000_0000, 32);
    rd_status(s); check("R4 32-bit program discarded", s, 8'h02);
  endtask

  task automatic t_program();
    logic [7:0] s;
    int polls;
    prog(32'h0000_0000, 40);
    rd_status(s); check("R10 status while busy", s, 8'h03);
    rd_prot(32'h0001_0000, s); check("R11 read ignored while busy", s, 8'h00);
    wait_idle(polls);
    check("R10 busy lasted past first poll", (polls > 1) ? 8'h01 : 8'h00, 8'h01);
    rd_status(s); check("R10 status after completion", s, 8'h00);
    rd_prot(32'h0000_FFFF, s); check("R6 R7 sector 0 top address protected", s, 8'h00);
    rd_prot(32'h0001_0000, s); check("R7 sector 1 unprotected", s, 8'hFF);
  endtask

  task automatic t_no_wel();
    logic [7:0] s;
    prog(32'h0002_0000, 40);
    rd_status(s); check("R5 program without latch: status", s, 8'h00);
    rd_prot(32'h0002_0000, s); check("R5 program without latch: byte", s, 8'hFF);
  endtask

  task automatic t_lock_clear();
    logic [7:0] s;
    int polls;
    cmd(8'hA6);
    rd_lock(s); check("R9 lock clear without latch ignored", s, 8'h01);
    cmd(8'h06);
    cmd(8'hA6);
    rd_status(s); check("R10 status while lock clear busy", s, 8'h03);
    cmd(8'h06);
    wait_idle(polls);
    rd_status(s); check("R11 write enable during busy ignored", s, 8'h00);
    rd_lock(s); check("R9 lock cleared", s, 8'h00);
  endtask

  task automatic t_locked_prog();
    logic [7:0] s;
    cmd(8'h06);
    prog(32'h0003_0000, 40);
    rd_status(s); check("R5 program while locked: latch kept", s, 8'h02);
    rd_prot(32'h0003_0000, s); check("R5 program while locked: byte", s, 8'hFF);
  endtask

  task automatic t_reset_keeps();
    logic [7:0] s;
    rst = 1'b1; clks(4); rst = 1'b0; clks(4);
    rd_status(s); check("R12 status cleared by reset", s, 8'h00);
    rd_lock(s);   check("R12 lock reopened by reset", s, 8'h01);
    rd_prot(32'h0000_8000, s); check("R12 protection kept over reset", s, 8'h00);
  endtask

  initial begin
    clks(6);
    rst = 1'b0;
    clks(6);
    t_reset_state();
    t_wren();
    t_bad_length();
    t_program();
    t_no_wel();
    t_lock_clear();
    t_locked_prog();
    t_reset_keeps();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule